// File: doc/BRIEF.md
# MESI Coherence Line-State Controller

This block keeps the four-state coherence tag (Modified, Exclusive, Shared, Invalid) for every line of a small private cache that sits on a shared snooping bus. The processor side presents read and write requests by line index. The snoop side presents read and write transactions that other caches put on the bus. A shared-line input tells the block whether some other cache already holds the line being filled. The data array, memory, and bus arbitration live elsewhere. The block only updates the tags and produces the commands that the rest of the cache must carry out.

Each request yields, one clock later, a registered bus command with its line index, a hit flag, and an invalidate broadcast flag. Each snoop yields, one clock later, a writeback request with its line index whenever dirty data must go back to memory. A local request and a snoop may arrive in the same cycle. When they target the same line, the snoop is applied first and the local request then sees the updated tag.

Top module: `mesi_line_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every line is Invalid and every output is 0 (bus_cmd encoding: 0 none, 1 read fill, 2 read-for-ownership, 3 upgrade).
- R2: A local read to an Invalid line gives bus_cmd=1 and hit=0 one cycle later. The line becomes Exclusive if `shared_in` was 0 and Shared if it was 1.
- R3: A local read to a valid line gives hit=1 and bus_cmd=0 one cycle later, and leaves the line's state unchanged.
- R4: A local write to an Exclusive line gives hit=1, bus_cmd=0 and inv_bcast=0, and moves the line to Modified.
- R5: A local write to a Shared line gives hit=1, bus_cmd=3 and inv_bcast=1 for one cycle, and moves the line to Modified.
- R6: A local write to an Invalid line gives bus_cmd=2 and hit=0, and moves the line to Modified.
- R7: A snooped read of a Modified line gives wb_req=1 with wb_idx equal to the snooped index one cycle later, and moves the line to Shared.
- R8: A snooped read of an Exclusive line moves it to Shared without a writeback.
- R9: A snooped write moves any valid line to Invalid. It raises wb_req only if the line was Modified.
- R10: A snoop to an Invalid line changes no state and raises no writeback.
- R11: When a snoop and a local request name the same line in one cycle, the local request is evaluated against the state the snoop produced.
- R12: A local write to a Modified line gives hit=1 and bus_cmd=0, and the line stays Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | Local request is a write (0 = read) |
| req_idx | input | IDX_W | Local request line index |
| snp_valid | input | 1 | Snooped transaction present |
| snp_write | input | 1 | Snooped transaction is a write (0 = read) |
| snp_idx | input | IDX_W | Snooped line index |
| shared_in | input | 1 | Another cache holds the requested line |
| bus_cmd | output | 2 | Registered bus command for the local request |
| bus_idx | output | IDX_W | Line index of bus_cmd |
| inv_bcast | output | 1 | Invalidate broadcast for other copies |
| hit | output | 1 | Local request found a valid line |
| wb_req | output | 1 | Dirty line must be written back |
| wb_idx | output | IDX_W | Line index of the writeback |

## Verification
The assertions check several things every cycle against the stored tags. A writeback appears only for a Modified line. Writes to Exclusive lines stay silent. Read misses issue a fill. Read hits leave their tag alone. Snooped writes leave the line Invalid. An upgrade always carries the invalidate flag. Other behaviours can only be shown by the bench's ordered scenarios: the choice between Exclusive and Shared on a fill, the full walks through the states, and the same-line collision where the snoop wins. In those scenarios the state is read back indirectly, through the command and writeback each later access produces.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RFO  = 2'd2,
    CMD_UPG  = 2'd3
  } buscmd_t;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_en,
  input  logic [IDX_W-1:0] loc_idx,
  input  mesi_t            loc_st,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  mesi_t            snp_st,
  output mesi_t            st_q [NUM_LINES]
);
  // The local port has priority. On a same-line collision the top enables
  // only the local port, which already carries the snoop-updated state.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        st_q[i] <= ST_I;
      else if (loc_en && (loc_idx == IDX_W'(i)))
        st_q[i] <= loc_st;
      else if (snp_en && (snp_idx == IDX_W'(i)))
        st_q[i] <= snp_st;
    end

    p_reset_inv_r1: assert property (@(posedge clk) rst |=> (st_q[i] == ST_I))
      else $error("line %0d not Invalid after reset", i);
  end
endmodule

// File: rtl/mesi_snoop_step.sv
module mesi_snoop_step
  import mesi_pkg::*;
(
  input  mesi_t cur,
  input  logic  is_write,
  output mesi_t nxt,
  output logic  dirty
);
  always_comb begin
    nxt   = cur;
    dirty = (cur == ST_M);
    if (is_write) begin
      nxt = ST_I;
    end else begin
      case (cur)
        ST_M, ST_E: nxt = ST_S;
        default:    nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/mesi_local_step.sv
module mesi_local_step
  import mesi_pkg::*;
(
  input  mesi_t   cur,
  input  logic    is_write,
  input  logic    shared_in,
  output mesi_t   nxt,
  output buscmd_t cmd,
  output logic    inv,
  output logic    hit
);
  always_comb begin
    nxt = cur;
    cmd = CMD_NONE;
    inv = 1'b0;
    hit = (cur != ST_I);
    if (is_write) begin
      nxt = ST_M;
      case (cur)
        ST_I: cmd = CMD_RFO;
        ST_S: begin
          cmd = CMD_UPG;
          inv = 1'b1;
        end
        default: cmd = CMD_NONE;
      endcase
    end else if (cur == ST_I) begin
      cmd = CMD_RD;
      nxt = shared_in ? ST_S : ST_E;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             shared_in,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  output logic             inv_bcast,
  output logic             hit,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx
);
  mesi_t   st_q [NUM_LINES];
  mesi_t   snp_cur, snp_nxt, loc_cur, loc_nxt;
  logic    snp_dirty, loc_inv, loc_hit, same_line;
  buscmd_t loc_cmd;

  assign snp_cur   = st_q[snp_idx];
  assign same_line = snp_valid && req_valid && (snp_idx == req_idx);
  // The snoop is applied first: a same-line local request sees its result.
  assign loc_cur   = same_line ? snp_nxt : st_q[req_idx];

  mesi_snoop_step u_snoop (
    .cur      (snp_cur),
    .is_write (snp_write),
    .nxt      (snp_nxt),
    .dirty    (snp_dirty)
  );

  mesi_local_step u_local (
    .cur       (loc_cur),
    .is_write  (req_write),
    .shared_in (shared_in),
    .nxt       (loc_nxt),
    .cmd       (loc_cmd),
    .inv       (loc_inv),
    .hit       (loc_hit)
  );

  mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .loc_en  (req_valid),
    .loc_idx (req_idx),
    .loc_st  (loc_nxt),
    .snp_en  (snp_valid && !same_line),
    .snp_idx (snp_idx),
    .snp_st  (snp_nxt),
    .st_q    (st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cmd   <= CMD_NONE;
      bus_idx   <= '0;
      inv_bcast <= 1'b0;
      hit       <= 1'b0;
      wb_req    <= 1'b0;
      wb_idx    <= '0;
    end else begin
      bus_cmd   <= req_valid ? loc_cmd : CMD_NONE;
      bus_idx   <= req_idx;
      inv_bcast <= req_valid && loc_inv;
      hit       <= req_valid && loc_hit;
      wb_req    <= snp_valid && snp_dirty;
      wb_idx    <= snp_idx;
    end
  end

  // R7, R9, R10: a writeback only follows a snoop to a Modified line
  p_wb_mod_only_r7: assert property (@(posedge clk) disable iff (rst)
    (!snp_valid || st_q[snp_idx] != ST_M) |=> !wb_req)
    else $error("writeback without Modified line");

  // R4: a write to Exclusive is silent and hits
  p_silent_exc_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !same_line && st_q[req_idx] == ST_E)
      |=> (bus_cmd == CMD_NONE && hit && !inv_bcast))
    else $error("write to Exclusive not silent");

  // R2: a read to an Invalid line issues a fill
  p_miss_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !same_line && st_q[req_idx] == ST_I)
      |=> (bus_cmd == CMD_RD && !hit))
    else $error("read miss without fill");

  // R3: a read hit keeps the tag
  p_rdhit_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !same_line && st_q[req_idx] != ST_I
      && !(snp_valid && snp_idx == req_idx))
      |=> (st_q[$past(req_idx)] == $past(st_q[req_idx])))
    else $error("read hit changed state");

  // R9: a snooped write leaves the line Invalid
  p_snpwr_inv_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_write && !same_line) |=> (st_q[$past(snp_idx)] == ST_I))
    else $error("snooped write left line valid");

  // R5: an upgrade is always accompanied by the invalidate broadcast
  p_upg_inv_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_UPG) |-> (inv_bcast && hit))
    else $error("upgrade without invalidate");
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int NL = 8;
  localparam int IW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 0, req_write = 0, snp_valid = 0, snp_write = 0, shared_in = 0;
  logic [IW-1:0] req_idx = '0, snp_idx = '0;
  logic [1:0]    bus_cmd;
  logic [IW-1:0] bus_idx, wb_idx;
  logic          inv_bcast, hit, wb_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_idx(snp_idx),
    .shared_in(shared_in),
    .bus_cmd(bus_cmd), .bus_idx(bus_idx), .inv_bcast(inv_bcast), .hit(hit),
    .wb_req(wb_req), .wb_idx(wb_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; outputs are sampled 1 ns after the capturing edge.
  task automatic cyc(input logic rv, input logic rw, input int ri,
                     input logic sv, input logic sw, input int si, input logic sh);
    @(negedge clk);
    req_valid = rv; req_write = rw; req_idx = IW'(ri);
    snp_valid = sv; snp_write = sw; snp_idx = IW'(si); shared_in = sh;
    @(posedge clk);
    #1;
    req_valid = 0; snp_valid = 0; req_write = 0; snp_write = 0; shared_in = 0;
  endtask

  task automatic rd(input int i, input logic sh); cyc(1, 0, i, 0, 0, 0, sh); endtask
  task automatic wr(input int i);                 cyc(1, 1, i, 0, 0, 0, 0);  endtask
  task automatic sn(input int i, input logic w);  cyc(0, 0, 0, 1, w, i, 0);  endtask

  task automatic t_reset;
    chk("R1 bus_cmd in reset", bus_cmd, 0);
    chk("R1 wb_req in reset", wb_req, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 hit after reset", hit, 0);
    chk("R1 inv after reset", inv_bcast, 0);
    for (int i = 0; i < NL; i++) begin
      rd(i, 1);
      chk("R1 line starts Invalid (read miss)", bus_cmd, 1);
      chk("R1 bus_idx", bus_idx, i);
    end
    for (int i = 0; i < NL; i++) begin
      sn(i, 1);   // clear lines again (Shared -> Invalid)
      chk("R9 snoop write on Shared no wb", wb_req, 0);
    end
  endtask

  task automatic t_exclusive_path;
    rd(1, 0);
    chk("R2 fill cmd", bus_cmd, 1);  chk("R2 fill hit", hit, 0);
    rd(1, 0);
    chk("R3 read hit", hit, 1);      chk("R3 read hit no cmd", bus_cmd, 0);
    wr(1);
    chk("R4 write E silent", bus_cmd, 0); chk("R4 hit", hit, 1); chk("R4 no inv", inv_bcast, 0);
    sn(1, 0);
    chk("R7 wb on M read snoop", wb_req, 1); chk("R7 wb_idx", wb_idx, 1);
    wr(1);
    chk("R7 line now Shared -> upgrade", bus_cmd, 3);
  endtask

  task automatic t_shared_path;
    rd(2, 1);
    chk("R2 shared fill cmd", bus_cmd, 1);
    wr(2);
    chk("R5 upgrade cmd", bus_cmd, 3); chk("R5 inv", inv_bcast, 1); chk("R5 hit", hit, 1);
    wr(2);
    chk("R12 write M no cmd", bus_cmd, 0); chk("R12 hit", hit, 1); chk("R5 inv one cycle", inv_bcast, 0);
    sn(2, 1);
    chk("R9 wb on M write snoop", wb_req, 1); chk("R9 wb_idx", wb_idx, 2);
    rd(2, 0);
    chk("R9 line Invalid after snoop write", bus_cmd, 1);
  endtask

  task automatic t_exc_snoop;
    rd(3, 0);
    sn(3, 0);
    chk("R8 E read snoop no wb", wb_req, 0);
    wr(3);
    chk("R8 E became Shared", bus_cmd, 3);
    rd(6, 0);
    sn(6, 1);
    chk("R9 E write snoop no wb", wb_req, 0);
    rd(6, 0);
    chk("R9 E line Invalid", bus_cmd, 1);
  endtask

  task automatic t_write_miss;
    wr(4);
    chk("R6 RFO cmd", bus_cmd, 2); chk("R6 miss", hit, 0); chk("R6 bus_idx", bus_idx, 4);
    wr(4);
    chk("R12 M write hit", hit, 1); chk("R6 now Modified", bus_cmd, 0);
    sn(4, 0);
    chk("R6 Modified wb", wb_req, 1);
  endtask

  task automatic t_invalid_snoop;
    sn(5, 1);
    chk("R10 snoop write Invalid no wb", wb_req, 0);
    sn(5, 0);
    chk("R10 snoop read Invalid no wb", wb_req, 0);
    rd(5, 0);
    chk("R10 line stays Invalid", bus_cmd, 1);
    wr(5);
    chk("R10 fill is Exclusive (silent write)", bus_cmd, 0);
  endtask

  task automatic t_collision;
    rd(7, 0);
    cyc(1, 1, 7, 1, 0, 7, 0);  // snoop read E->S, then local write on S
    chk("R11 collide wb none", wb_req, 0);
    chk("R11 collide upgrade", bus_cmd, 3);
    chk("R11 collide inv", inv_bcast, 1);
    sn(7, 0);
    chk("R11 line Modified after collide", wb_req, 1);
    cyc(1, 0, 7, 1, 1, 7, 1);  // snoop write S->I, then local read misses
    chk("R11 collide read miss", bus_cmd, 1);
    chk("R11 collide read hit flag", hit, 0);
    wr(7);
    chk("R11 refill Shared -> upgrade", bus_cmd, 3);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_exclusive_path();
    t_shared_path();
    t_exc_snoop();
    t_write_miss();
    t_invalid_snoop();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule